// File: doc/BRIEF.md
# Serial Register Port with Guarded Software Reset

This block connects an external serial master to a bank of sixteen 8-bit registers. The master uses a three-wire capable serial protocol with an active-high chip select. Each transfer opens with a command byte, which picks a direction and a starting register. Any number of data bytes follow, and the register pointer steps forward after each byte. The serial pins are sampled with the system clock. A short synchronizer and edge detector recover the serial clock edges, so the bank lives entirely in the system clock domain.

The clock, alarm and timer logic see every register through a flat image output. They are told about each completed write by a one-cycle strobe that carries the address and the stored value. A read burst raises a one-cycle pulse carrying its start address, so that logic can freeze or snapshot its counters. The data output is enabled only while the block is returning read data, so that line can be tied to the data input for single-wire use.

Writing one specific code to register 0 does not store anything. It raises a software-reset pulse and returns the control, alarm-enable, offset and clock-output/timer registers to their defaults. Any other value written to register 0 is an ordinary write.

Top module: `rtc_spi_regs`

## Requirements
- R1: The first byte after chip select rises is a command. Bit 7 = 1 means read and 0 means write. Bits 6:4 must equal 001 and bits 3:0 give the start address. A command with any other value in bits 6:4 makes the block ignore the rest of the transfer: no strobe, no pulse, no register change.
- R2: Each complete write data byte is stored at the current address ANDed with that address's implemented-bit mask. The same cycle, wr_stb pulses high for one clock with wr_addr and the masked wr_data.
- R3: The address advances by one after every data byte, in reads and writes alike, and wraps from 15 to 0.
- R4: The serial clock idles low. Input bits are taken on rising edges, MSB first. Read data is placed on spi_sdo on falling edges, MSB first, starting at the falling edge that follows the last command bit. spi_sdo_en is high only during the data phase of a read with chip select high.
- R5: Bits outside the implemented-bit mask always read and hold 0. The masks for addresses 0 to 15 in hex are A6, FF, FF, 7F, 3F, 3F, 07, 1F, FF, FF, BF, BF, 87, FF, 7B, FF.
- R6: Dropping chip select aborts any partial byte. The next transfer begins with a fresh command byte.
- R7: Writing exactly 58h to address 0 pulses soft_rst for one clock and raises no wr_stb. It stores nothing into address 0 itself. Registers 0, 1 and 13 become 00h, register 14 becomes 03h, and bit 7 of registers 9 to 12 is set with their other bits kept. All other registers are unchanged.
- R8: Any other value written to address 0 is an ordinary masked write and causes no software reset.
- R9: Hardware reset sets registers 2 and 9 to 12 to 80h, register 14 to 03h and all others to 00h. It also leaves spi_sdo_en low.
- R10: Each read burst pulses rd_stb for one clock with rd_addr equal to the burst's start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_ce | input | 1 | Chip select, active high |
| spi_scl | input | 1 | Serial clock from the master |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out, valid when spi_sdo_en is high |
| spi_sdo_en | output | 1 | Output enable for the data-out driver |
| wr_stb | output | 1 | One-cycle strobe per stored write byte |
| wr_addr | output | 4 | Address of the stored byte |
| wr_data | output | 8 | Masked value that was stored |
| rd_stb | output | 1 | One-cycle pulse at the start of a read burst |
| rd_addr | output | 4 | Start address of that read burst |
| soft_rst | output | 1 | One-cycle software-reset pulse |
| reg_image | output | 128 | All sixteen registers, register n in bits 8n+7:8n |

## Verification
A wrong bit counter or address pointer shows up in the very next read burst as bytes shifted or taken from the wrong register, and in the write strobes as wrong addresses a few clocks after the byte completes. A faulty reset-code qualifier shows at once in reg_image: control or timer defaults are lost after the code, or they reappear after a near-miss value. A leaky mask shows up as a nonzero unimplemented bit on the first readback. Random bursts run against a bench register model, so any divergence is caught by the next byte read.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

    localparam int REG_W   = 8;
    localparam int ADDR_W  = 4;
    localparam int NUM_REG = 1 << ADDR_W;
    localparam int IMG_W   = NUM_REG * REG_W;

    typedef logic [REG_W-1:0]  byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_WR   = 2'd1,
        PH_RD   = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        byte_t data;
    } wbyte_t;

    // bits that physically exist in each register
    function automatic byte_t impl_mask(input addr_t a);
        case (a)
            4'd0:    impl_mask = 8'hA6;
            4'd3:    impl_mask = 8'h7F;
            4'd4:    impl_mask = 8'h3F;
            4'd5:    impl_mask = 8'h3F;
            4'd6:    impl_mask = 8'h07;
            4'd7:    impl_mask = 8'h1F;
            4'd10:   impl_mask = 8'hBF;
            4'd11:   impl_mask = 8'hBF;
            4'd12:   impl_mask = 8'h87;
            4'd14:   impl_mask = 8'h7B;
            default: impl_mask = 8'hFF;
        endcase
    endfunction

    function automatic logic [IMG_W-1:0] image_mask();
        logic [IMG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_REG; i++) begin
            m[i*REG_W +: REG_W] = impl_mask(addr_t'(i));
        end
        return m;
    endfunction

    // power-up contents
    function automatic byte_t hard_value(input addr_t a);
        case (a)
            4'd2, 4'd9, 4'd10, 4'd11, 4'd12: hard_value = 8'h80;
            4'd14:                           hard_value = 8'h03;
            default:                         hard_value = 8'h00;
        endcase
    endfunction

    // contents after the guarded software reset
    function automatic byte_t soft_value(input addr_t a, input byte_t cur);
        case (a)
            4'd0, 4'd1, 4'd13:        soft_value = 8'h00;
            4'd9, 4'd10, 4'd11, 4'd12: soft_value = cur | 8'h80;
            4'd14:                    soft_value = 8'h03;
            default:                  soft_value = cur;
        endcase
    endfunction

endpackage

// File: rtl/rsr_sync.sv
module rsr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign q    = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/rsr_frame.sv
module rsr_frame
    import rsr_pkg::*;
#(
    parameter logic [2:0] SUB_ADDR = 3'b001
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ce,
    input  logic   scl_rise,
    input  logic   scl_fall,
    input  logic   sdi,
    input  byte_t  rd_data,
    output addr_t  cur_addr,
    output logic   sdo,
    output logic   sdo_en,
    output wbyte_t wb,
    output logic   rd_pulse,
    output addr_t  rd_pulse_addr
);
    localparam int CNT_W = $clog2(REG_W);

    phase_e             phase;
    logic [CNT_W-1:0]   bit_cnt;
    byte_t              shreg;
    addr_t              addr_q;
    logic               sdo_q;
    byte_t              full;

    assign full = {shreg[REG_W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase         <= PH_CMD;
            bit_cnt       <= '0;
            shreg         <= '0;
            addr_q        <= '0;
            sdo_q         <= 1'b0;
            wb            <= '0;
            rd_pulse      <= 1'b0;
            rd_pulse_addr <= '0;
        end else begin
            wb.valid <= 1'b0;
            rd_pulse <= 1'b0;
            if (!ce) begin
                phase   <= PH_CMD;
                bit_cnt <= '0;
            end else begin
                if (scl_rise) begin
                    shreg   <= full;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(REG_W - 1)) begin
                        case (phase)
                            PH_CMD: begin
                                if (full[6:4] == SUB_ADDR) begin
                                    addr_q <= full[ADDR_W-1:0];
                                    if (full[7]) begin
                                        phase         <= PH_RD;
                                        rd_pulse      <= 1'b1;
                                        rd_pulse_addr <= full[ADDR_W-1:0];
                                    end else begin
                                        phase <= PH_WR;
                                    end
                                end else begin
                                    phase <= PH_SKIP;
                                end
                            end
                            PH_WR: begin
                                wb.valid <= 1'b1;
                                wb.addr  <= addr_q;
                                wb.data  <= full;
                                addr_q   <= addr_q + 1'b1;
                            end
                            PH_RD: begin
                                addr_q <= addr_q + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                if (scl_fall && phase == PH_RD) begin
                    sdo_q <= rd_data[~bit_cnt];
                end
            end
        end
    end

    assign cur_addr = addr_q;
    assign sdo      = sdo_q;
    assign sdo_en   = ce && (phase == PH_RD);
endmodule

// File: rtl/rsr_bank.sv
module rsr_bank
    import rsr_pkg::*;
#(
    parameter logic [7:0] SRST_CODE = 8'h58
) (
    input  logic              clk,
    input  logic              rst,
    input  wbyte_t            wb,
    input  addr_t             rd_addr,
    output byte_t             rd_data,
    output logic [IMG_W-1:0]  image,
    output logic              wr_stb,
    output addr_t             wr_addr,
    output byte_t             wr_data,
    output logic              soft_rst
);
    byte_t mem [NUM_REG];
    logic  is_code;

    assign is_code = (wb.addr == '0) && (wb.data == SRST_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REG; i++) mem[i] <= hard_value(addr_t'(i));
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            soft_rst <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            soft_rst <= 1'b0;
            if (wb.valid) begin
                if (is_code) begin
                    for (int i = 0; i < NUM_REG; i++)
                        mem[i] <= soft_value(addr_t'(i), mem[i]);
                    soft_rst <= 1'b1;
                end else begin
                    mem[wb.addr] <= wb.data & impl_mask(wb.addr);
                    wr_stb       <= 1'b1;
                    wr_addr      <= wb.addr;
                    wr_data      <= wb.data & impl_mask(wb.addr);
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

    for (genvar g = 0; g < NUM_REG; g++) begin : g_img
        assign image[g*REG_W +: REG_W] = mem[g];
    end
endmodule

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs
    import rsr_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] SUB_ADDR    = 3'b001,
    parameter logic [7:0] SRST_CODE   = 8'h58
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         spi_ce,
    input  logic         spi_scl,
    input  logic         spi_sdi,
    output logic         spi_sdo,
    output logic         spi_sdo_en,
    output logic         wr_stb,
    output logic [3:0]   wr_addr,
    output logic [7:0]   wr_data,
    output logic         rd_stb,
    output logic [3:0]   rd_addr,
    output logic         soft_rst,
    output logic [127:0] reg_image
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pin_raw, pin_q, pin_rise, pin_fall;
    assign pin_raw = {spi_sdi, spi_scl, spi_ce};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        rsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (pin_raw[g]),
            .q    (pin_q[g]),
            .rise (pin_rise[g]),
            .fall (pin_fall[g])
        );
    end

    wbyte_t wb;
    addr_t  cur_addr;
    byte_t  rd_data;

    rsr_frame #(.SUB_ADDR(SUB_ADDR)) u_frame (
        .clk           (clk),
        .rst           (rst),
        .ce            (pin_q[0]),
        .scl_rise      (pin_rise[1]),
        .scl_fall      (pin_fall[1]),
        .sdi           (pin_q[2]),
        .rd_data       (rd_data),
        .cur_addr      (cur_addr),
        .sdo           (spi_sdo),
        .sdo_en        (spi_sdo_en),
        .wb            (wb),
        .rd_pulse      (rd_stb),
        .rd_pulse_addr (rd_addr)
    );

    rsr_bank #(.SRST_CODE(SRST_CODE)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wb       (wb),
        .rd_addr  (cur_addr),
        .rd_data  (rd_data),
        .image    (reg_image),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .soft_rst (soft_rst)
    );
endmodule

// File: rtl/rsr_checker.sv
module rsr_checker
    import rsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         spi_ce,
    input logic         spi_sdo_en,
    input logic         wr_stb,
    input logic [3:0]   wr_addr,
    input logic [7:0]   wr_data,
    input logic         rd_stb,
    input logic         soft_rst,
    input logic [127:0] reg_image
);
    localparam int LOW_LIM = SYNC_STAGES + 2;
    localparam logic [IMG_W-1:0] ALL_MASK = image_mask();

    int ce_low_cnt;
    always_ff @(posedge clk) begin
        if (rst || spi_ce) ce_low_cnt <= 0;
        else if (ce_low_cnt < LOW_LIM) ce_low_cnt <= ce_low_cnt + 1;
    end

    // R4: driver released once chip select has been low long enough
    a_r4_sdo_released: assert property (@(posedge clk) disable iff (rst)
        (ce_low_cnt >= LOW_LIM) |-> !spi_sdo_en);

    // R5: unimplemented bits never hold a one
    a_r5_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_image & ~ALL_MASK) == '0);

    // R2: strobed data never carries unimplemented bits
    a_r2_strobe_masked: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (wr_data & ~impl_mask(wr_addr)) == '0);

    // R7: reset code raises no write strobe and lands defaults
    a_r7_no_strobe: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> !wr_stb);
    a_r7_defaults: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (reg_image[7:0] == 8'h00 && reg_image[119:112] == 8'h03));
    a_r7_single: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst);

    // R10: read pulse lasts one clock
    a_r10_rd_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_stb);
endmodule

bind rtc_spi_regs rsr_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .spi_ce     (spi_ce),
    .spi_sdo_en (spi_sdo_en),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_stb     (rd_stb),
    .soft_rst   (soft_rst),
    .reg_image  (reg_image)
);

// File: tb/sim_rtc_spi_regs.sv
module sim_rtc_spi_regs;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_ce = 1'b0, spi_scl = 1'b0, spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_en, wr_stb, rd_stb, soft_rst;
    logic [3:0] wr_addr, rd_addr;
    logic [7:0] wr_data;
    logic [127:0] reg_image;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_spi_regs u0 (
        .clk(clk), .rst(rst), .spi_ce(spi_ce), .spi_scl(spi_scl), .spi_sdi(spi_sdi),
        .spi_sdo(spi_sdo), .spi_sdo_en(spi_sdo_en), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_addr(rd_addr), .soft_rst(soft_rst),
        .reg_image(reg_image)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;
    int wr_cnt = 0, rd_cnt = 0, srst_cnt = 0;
    logic [3:0] last_rd_addr, last_wr_addr;
    logic [7:0] last_wr_data;
    logic [7:0] model [16];
    logic [7:0] tx [8];
    logic [7:0] rx [8];
    bit en_seen;

    always @(posedge clk) begin
        if (!rst) begin
            if (wr_stb) begin wr_cnt++; last_wr_addr <= wr_addr; last_wr_data <= wr_data; end
            if (rd_stb) begin rd_cnt++; last_rd_addr <= rd_addr; end
            if (soft_rst) srst_cnt++;
        end
    end

    function automatic logic [7:0] mask_of(input int a);
        logic [7:0] m [16] = '{8'hA6, 8'hFF, 8'hFF, 8'h7F, 8'h3F, 8'h3F, 8'h07, 8'h1F,
                               8'hFF, 8'hFF, 8'hBF, 8'hBF, 8'h87, 8'hFF, 8'h7B, 8'hFF};
        return m[a];
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send cmd then n data bytes from tx[]; captures rx[] when reading
    task automatic xfer(input logic [7:0] cmd, input int n);
        logic [7:0] b;
        spi_ce = 1'b1;
        en_seen = 1'b0;
        ticks(HALF);
        for (int k = 0; k <= n; k++) begin
            b = (k == 0) ? cmd : tx[k-1];
            for (int i = 7; i >= 0; i--) begin
                spi_sdi = b[i];
                ticks(HALF);
                if (k > 0) begin rx[k-1][i] = spi_sdo; if (spi_sdo_en) en_seen = 1'b1; end
                spi_scl = 1'b1;
                ticks(HALF);
                spi_scl = 1'b0;
            end
        end
        ticks(HALF);
        spi_ce = 1'b0;
        ticks(8);
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        if (a == 0 && d == 8'h58) begin
            model[0] = 0; model[1] = 0; model[13] = 0; model[14] = 8'h03;
            for (int j = 9; j <= 12; j++) model[j] = model[j] | 8'h80;
        end else begin
            model[a] = d & mask_of(a);
        end
    endtask

    task automatic do_write(input int a, input int n);
        xfer({4'b0001, 4'(a)}, n);
        for (int k = 0; k < n; k++) model_write((a + k) % 16, tx[k]);
    endtask

    task automatic do_read_check(input int a, input int n, input string req);
        int rc;
        rc = rd_cnt;
        xfer({4'b1001, 4'(a)}, n);
        for (int k = 0; k < n; k++)
            check(rx[k] == model[(a + k) % 16], req, rx[k], model[(a + k) % 16]);
        check(rd_cnt == rc + 1 && last_rd_addr == 4'(a), "R10 rd_stb", {rd_cnt, last_rd_addr}, {rc + 1, 4'(a)});
        check(en_seen, "R4 sdo_en during read", en_seen, 1);
    endtask

    task automatic check_image(input string req);
        logic [127:0] e;
        for (int j = 0; j < 16; j++) e[j*8 +: 8] = model[j];
        check(reg_image == e, req, reg_image, e);
    endtask

    initial begin
        int wc, sc, len, a;
        for (int j = 0; j < 16; j++) model[j] = 8'h00;
        model[2] = 8'h80; for (int j = 9; j <= 12; j++) model[j] = 8'h80; model[14] = 8'h03;
        ticks(5);
        rst = 1'b0;
        ticks(3);
        check_image("R9 hard reset values");
        check(spi_sdo_en == 1'b0, "R9 sdo_en low after reset", spi_sdo_en, 0);

        // R2/R5: burst write with masking, strobe content
        wc = wr_cnt;
        tx[0] = 8'hFF; tx[1] = 8'hFF; tx[2] = 8'hFF; tx[3] = 8'hFF;
        do_write(3, 4);
        check(wr_cnt == wc + 4, "R2 one strobe per byte", wr_cnt, wc + 4);
        check(last_wr_addr == 4'd6 && last_wr_data == 8'h07, "R2 strobe addr/data", {last_wr_addr, last_wr_data}, {4'd6, 8'h07});
        check_image("R5 masked write burst");
        do_read_check(3, 4, "R5 read masked");

        // R3: wrap 15 -> 0
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'hA6; tx[3] = 8'h33;
        do_write(14, 4);
        check_image("R3 wrap write");
        do_read_check(14, 4, "R3 wrap read");

        // R8: near-miss value to address 0 is an ordinary write
        sc = srst_cnt;
        tx[0] = 8'h5A;
        do_write(0, 1);
        check(srst_cnt == sc, "R8 no soft reset", srst_cnt, sc);
        check_image("R8 ordinary write to 0");

        // R7: exact code
        tx[0] = 8'h44; do_write(13, 1);
        tx[0] = 8'h77; do_write(12, 1);
        wc = wr_cnt; sc = srst_cnt;
        tx[0] = 8'h58;
        do_write(0, 1);
        check(srst_cnt == sc + 1, "R7 soft_rst pulse", srst_cnt, sc + 1);
        check(wr_cnt == wc, "R7 no wr_stb", wr_cnt, wc);
        check_image("R7 soft reset contents");

        // R1: wrong sub-address ignored
        wc = wr_cnt;
        tx[0] = 8'hFF; tx[1] = 8'hFF;
        xfer(8'h45, 2);
        check(wr_cnt == wc, "R1 bad sub-address no strobe", wr_cnt, wc);
        check_image("R1 bad sub-address no change");

        // R6: abort mid-byte, then a full command
        spi_ce = 1'b1; ticks(HALF);
        for (int i = 0; i < 4; i++) begin
            spi_sdi = 1'b1; ticks(HALF); spi_scl = 1'b1; ticks(HALF); spi_scl = 1'b0;
        end
        spi_ce = 1'b0; ticks(8);
        check(spi_sdo_en == 1'b0, "R4 sdo_en low with ce low", spi_sdo_en, 0);
        tx[0] = 8'h5C;
        do_write(8, 1);
        check_image("R6 fresh command after abort");

        // random bursts
        void'($urandom(32'd1234));
        for (int t = 0; t < 40; t++) begin
            len = 1 + ($urandom % 5);
            a = $urandom % 16;
            if ($urandom % 2) begin
                for (int k = 0; k < len; k++) tx[k] = 8'($urandom);
                do_write(a, len);
                check_image("R2 random write");
            end else begin
                for (int k = 0; k < len; k++) tx[k] = 8'h00;
                do_read_check(a, len, "R4 random read");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule